// File: doc/BRIEF.md
# Double-Buffered DAC Input Register

This block is the digital front end of a 16-bit digital-to-analog converter, modelled in one system clock domain. A parallel data word enters a first holding rank under two active-low enables. A second rank holds the code that the converter actually uses. That second rank is refreshed from the first by a load strobe of its own. The strobe does not depend on the chip select or on any other control, so several converters on one board can share a strobe and change their outputs in the same cycle.

From the held code the block produces the drive word for a segmented converter. The upper nibble becomes a run of equal-weight thermometer lines. The lower twelve bits pass through as binary weights. A configuration input flips the MSB as a word is captured, so that two's-complement data can be used. A second configuration input selects how the code is read as a signed level: straight binary or offset binary. A one-cycle flag marks every cycle in which the output code moved.

Tying the chip select to the strobe and holding the first-rank enable low gives an edge-triggered mode. While the pair is low, the first rank tracks the bus. On the cycle the pair rises, the output takes the word that was captured just before that rise.

Top module: `dac_dbuf`

## Requirements
- R1: While `rst` is high at a clock edge, both ranks clear to 0x0000. After that edge `code`, `seg_lines`, `bin_lines` and `code_chg` are all zero.
- R2: At a clock edge where `cs_n` and `ld1_n` are both low, the first rank captures `bus_data`. At an edge where either one is high, the first rank keeps its value.
- R3: At an edge with `upd` high, `code` takes the first rank's value for that edge. At an edge with `upd` low, `code` keeps its value, so the last word is frozen when the strobe falls.
- R4: `upd` acts whatever the level of `cs_n` and `ld1_n`. With `cs_n` high and `upd` high, the word already held in the first rank is still moved to `code`.
- R5: At an edge with `cs_n` low, `ld1_n` low and `upd` high, both ranks pass the bus through. `code` shows that edge's `bus_data`, after the optional MSB flip, in the next cycle.
- R6: In edge mode, `cs_n` is driven equal to `upd` and `ld1_n` is held low. At the first edge where the pair is high, `code` takes the word on the bus at the edge before it, not the word present at the rising edge.
- R7: `seg_lines` bit i (i = 0..14) is high exactly when `code[15:12]` is greater than i. So for a nibble value n, only the lowest n lines are set.
- R8: `bin_lines` equals `code[11:0]`, and bit 0 is the LSB.
- R9: When `twos_in` is high at a capturing edge, bit 15 of the bus word is inverted before it is stored. The other bits are stored unchanged.
- R10: `level` is a 17-bit two's-complement value. It equals `code` when `bipolar` is low and `code - 32768` when `bipolar` is high. So 0x0000 gives -32768, 0x8000 gives 0 and 0xFFFF gives 32767.
- R11: `code_chg` is high for exactly the cycles in which `code` differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 16 | Parallel data word |
| cs_n | input | 1 | Chip select, active low, gates the first rank |
| ld1_n | input | 1 | First-rank load enable, active low |
| upd | input | 1 | Ungated load strobe for the second rank, active high |
| twos_in | input | 1 | Inverts the MSB as a word is captured (two's-complement input) |
| bipolar | input | 1 | Selects offset-binary reading of `level` |
| code | output | 16 | Held converter code (second rank) |
| seg_lines | output | 15 | Thermometer lines from the upper nibble |
| bin_lines | output | 12 | Binary-weighted lines from the lower bits |
| level | output | 17 | Signed level of `code` in LSBs |
| code_chg | output | 1 | High in each cycle in which `code` changed |

## Verification
The bench goes after these cases:
- **Ungated strobe.** With the chip select high, a strobe must still move the held word. A design that gated the strobe would leave the old code in place.
- **Edge mode.** The bus changes on the very edge where the tied pair rises. A design that loaded through instead of holding would deliver that late word.
- **Thermometer extremes.** Nibble values 0, 7, 8 and 15 catch an off-by-one decoder, which would light one line too many or too few.
- **Two's-complement and bipolar ends.** These expose a wrong bit flip or a wrong midscale offset.
- **Reloading an equal word.** This checks that the change flag stays low when the code does not move.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

    localparam int CODE_W_DEF = 16;
    localparam int SEG_W_DEF  = 4;

    typedef struct packed {
        logic cs_n;
        logic ld1_n;
        logic upd;
        logic twos;
    } ctl_t;

    typedef enum logic [1:0] {
        RK_HOLD    = 2'd0,
        RK_CAPTURE = 2'd1
    } rank_act_e;

    function automatic rank_act_e first_rank_act(input ctl_t c);
        return (!c.cs_n && !c.ld1_n) ? RK_CAPTURE : RK_HOLD;
    endfunction

    function automatic rank_act_e second_rank_act(input ctl_t c);
        return c.upd ? RK_CAPTURE : RK_HOLD;
    endfunction

endpackage

// File: rtl/dac_dbuf_rank_in.sv
module dac_dbuf_rank_in
    import dac_dbuf_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [CODE_W-1:0] bus,
    output logic [CODE_W-1:0] held,
    output logic [CODE_W-1:0] nxt
);

    localparam logic [CODE_W-1:0] MSB_MASK = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] conv;

    always_comb begin
        conv = ctl.twos ? (bus ^ MSB_MASK) : bus;
        unique case (first_rank_act(ctl))
            RK_CAPTURE: nxt = conv;
            default:    nxt = held;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else begin
            held <= nxt;
        end
    end

endmodule

// File: rtl/dac_dbuf_rank_out.sv
module dac_dbuf_rank_out
    import dac_dbuf_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [CODE_W-1:0] src,
    output logic [CODE_W-1:0] code,
    output logic              moved
);

    logic load;

    always_comb begin
        load = (second_rank_act(ctl) == RK_CAPTURE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code  <= '0;
            moved <= 1'b0;
        end else begin
            moved <= load && (src != code);
            if (load) begin
                code <= src;
            end
        end
    end

endmodule

// File: rtl/dac_dbuf_segdec.sv
module dac_dbuf_segdec
    import dac_dbuf_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF,
    parameter int SEG_W  = SEG_W_DEF,
    localparam int LINES = (1 << SEG_W) - 1,
    localparam int BIN_W = CODE_W - SEG_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [LINES-1:0]  seg,
    output logic [BIN_W-1:0]  bin
);

    logic [SEG_W-1:0] top;

    assign top = code[CODE_W-1 -: SEG_W];
    assign bin = code[BIN_W-1:0];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        localparam logic [SEG_W:0] IDX = (SEG_W+1)'(g);
        assign seg[g] = ({1'b0, top} > IDX);
    end

endmodule

// File: rtl/dac_dbuf.sv
module dac_dbuf
    import dac_dbuf_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF,
    parameter int SEG_W  = SEG_W_DEF,
    localparam int LINES = (1 << SEG_W) - 1,
    localparam int BIN_W = CODE_W - SEG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] bus_data,
    input  logic              cs_n,
    input  logic              ld1_n,
    input  logic              upd,
    input  logic              twos_in,
    input  logic              bipolar,
    output logic [CODE_W-1:0] code,
    output logic [LINES-1:0]  seg_lines,
    output logic [BIN_W-1:0]  bin_lines,
    output logic [CODE_W:0]   level,
    output logic              code_chg
);

    localparam logic [CODE_W:0] MID = (CODE_W+1)'(1) << (CODE_W-1);

    ctl_t              ctl;
    logic [CODE_W-1:0] r1_q;
    logic [CODE_W-1:0] r1_d;

    assign ctl = '{cs_n: cs_n, ld1_n: ld1_n, upd: upd, twos: twos_in};

    dac_dbuf_rank_in #(.CODE_W(CODE_W)) u_rin (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .bus  (bus_data),
        .held (r1_q),
        .nxt  (r1_d)
    );

    dac_dbuf_rank_out #(.CODE_W(CODE_W)) u_rout (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .src   (r1_d),
        .code  (code),
        .moved (code_chg)
    );

    dac_dbuf_segdec #(.CODE_W(CODE_W), .SEG_W(SEG_W)) u_dec (
        .code (code),
        .seg  (seg_lines),
        .bin  (bin_lines)
    );

    always_comb begin
        level = bipolar ? ({1'b0, code} - MID) : {1'b0, code};
    end

endmodule

// File: rtl/dac_dbuf_chk.sv
module dac_dbuf_chk #(
    parameter int CODE_W = 16,
    parameter int SEG_W  = 4,
    localparam int LINES = (1 << SEG_W) - 1,
    localparam int BIN_W = CODE_W - SEG_W
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] bus_data,
    input logic              cs_n,
    input logic              ld1_n,
    input logic              upd,
    input logic              twos_in,
    input logic              bipolar,
    input logic [CODE_W-1:0] code,
    input logic [LINES-1:0]  seg_lines,
    input logic [BIN_W-1:0]  bin_lines,
    input logic [CODE_W:0]   level,
    input logic              code_chg
);

    localparam logic [CODE_W:0] MID = (CODE_W+1)'(1) << (CODE_W-1);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (code == '0) && !code_chg);

    // R3
    a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(code));

    // R5 and R9
    a_r5_transparent: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ld1_n && upd) |=>
        code == ($past(bus_data) ^ {$past(twos_in), {(CODE_W-1){1'b0}}}));

    // R7
    a_r7_thermo_count: assert property (@(posedge clk) disable iff (rst)
        $countones(seg_lines) == int'(code[CODE_W-1 -: SEG_W]));

    // R7
    a_r7_thermo_shape: assert property (@(posedge clk) disable iff (rst)
        ((seg_lines + 1'b1) & seg_lines) == '0);

    // R8
    a_r8_binary_path: assert property (@(posedge clk) disable iff (rst)
        bin_lines == code[BIN_W-1:0]);

    // R10
    a_r10_level: assert property (@(posedge clk) disable iff (rst)
        level == (bipolar ? ({1'b0, code} - MID) : {1'b0, code}));

    // R11
    a_r11_flag_needs_move: assert property (@(posedge clk) disable iff (rst)
        code_chg |-> !$stable(code));

    // R11
    a_r11_move_sets_flag: assert property (@(posedge clk) disable iff (rst)
        !$stable(code) |-> code_chg);

endmodule

bind dac_dbuf dac_dbuf_chk #(.CODE_W(CODE_W), .SEG_W(SEG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_data  (bus_data),
    .cs_n      (cs_n),
    .ld1_n     (ld1_n),
    .upd       (upd),
    .twos_in   (twos_in),
    .bipolar   (bipolar),
    .code      (code),
    .seg_lines (seg_lines),
    .bin_lines (bin_lines),
    .level     (level),
    .code_chg  (code_chg)
);

// File: tb/sim_dac_dbuf.sv
`timescale 1ns/1ps
module sim_dac_dbuf;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_data = '0;
    logic        cs_n = 1'b1;
    logic        ld1_n = 1'b1;
    logic        upd = 1'b0;
    logic        twos_in = 1'b0;
    logic        bipolar = 1'b0;
    logic [15:0] code;
    logic [14:0] seg_lines;
    logic [11:0] bin_lines;
    logic [16:0] level;
    logic        code_chg;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_r1 = '0;
    logic [15:0] m_r2 = '0;
    logic        m_chg = 1'b0;

    always #5 clk = ~clk;

    dac_dbuf u0 (
        .clk(clk), .rst(rst), .bus_data(bus_data), .cs_n(cs_n), .ld1_n(ld1_n),
        .upd(upd), .twos_in(twos_in), .bipolar(bipolar), .code(code),
        .seg_lines(seg_lines), .bin_lines(bin_lines), .level(level),
        .code_chg(code_chg)
    );

    function automatic logic [14:0] exp_thermo(input logic [3:0] n);
        logic [14:0] t;
        for (int i = 0; i < 15; i++) t[i] = (i < int'(n));
        return t;
    endfunction

    function automatic logic [16:0] exp_level(input logic [15:0] c, input logic b);
        int v;
        v = b ? int'(c) - 32768 : int'(c);
        return 17'(v);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R3 code"}, 32'(code), 32'(m_r2));
        chk("R7 seg_lines", 32'(seg_lines), 32'(exp_thermo(m_r2[15:12])));
        chk("R8 bin_lines", 32'(bin_lines), 32'(m_r2[11:0]));
        chk("R10 level", 32'(level), 32'(exp_level(m_r2, bipolar)));
        chk("R11 code_chg", 32'(code_chg), 32'(m_chg));
    endtask

    task automatic step(input logic [15:0] d, input logic c, input logic l,
                        input logic u, input logic tw, input logic bp, input string tag);
        logic [15:0] n1;
        @(negedge clk);
        bus_data = d; cs_n = c; ld1_n = l; upd = u; twos_in = tw; bipolar = bp;
        @(posedge clk);
        n1 = (!c && !l) ? (d ^ {tw, 15'b0}) : m_r1;
        m_chg = u && (n1 != m_r2);
        if (u) m_r2 = n1;
        m_r1 = n1;
        #1;
        check_all(tag);
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog R1..R11 actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0669));
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset code", 32'(code), 32'h0);
        chk("R1 reset seg", 32'(seg_lines), 32'h0);
        chk("R1 reset bin", 32'(bin_lines), 32'h0);
        chk("R1 reset chg", 32'(code_chg), 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R2 / R3 / R4: load into rank one, ignore disabled load, ungated strobe
        step(16'hA5C3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 load no strobe");
        chk("R3 code held at zero", 32'(code), 32'h0);
        step(16'h1234, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R2 ld1 high ignored");
        step(16'h1234, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4 strobe with cs high");
        chk("R4 ungated strobe moves held word", 32'(code), 32'hA5C3);
        step(16'h4444, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 strobe low holds");
        chk("R3 frozen after strobe fall", 32'(code), 32'hA5C3);

        // R5 transparent path and R7 corners
        step(16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 transparent 0000");
        chk("R7 nibble 0", 32'(seg_lines), 32'h0);
        step(16'h7FFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 transparent 7FFF");
        chk("R7 nibble 7", 32'(seg_lines), 32'h007F);
        step(16'h8000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 transparent 8000");
        chk("R7 nibble 8", 32'(seg_lines), 32'h00FF);
        step(16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 transparent FFFF");
        chk("R7 nibble 15", 32'(seg_lines), 32'h7FFF);
        chk("R8 all ones", 32'(bin_lines), 32'hFFF);

        // R11 reload of an equal word keeps flag low
        step(16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R11 equal reload");
        chk("R11 no change no flag", 32'(code_chg), 32'h0);

        // R6 edge mode: cs tied to strobe, ld1 low
        step(16'h0F0F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 pair low");
        step(16'h3C3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 pair low");
        step(16'hDEAD, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 pair rise");
        chk("R6 word before edge delivered", 32'(code), 32'h3C3C);
        step(16'hBEEF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 pair high");
        chk("R6 held while pair high", 32'(code), 32'h3C3C);

        // R9 two's-complement input
        step(16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R9 twos zero");
        chk("R9 zero maps to midscale", 32'(code), 32'h8000);
        step(16'h7FFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R9 twos max");
        chk("R9 max maps to FFFF", 32'(code), 32'hFFFF);
        chk("R10 bipolar top", 32'(level), 32'(17'h07FFF));

        // R10 bipolar ends
        step(16'h8000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R10 bipolar mid");
        chk("R10 midscale zero", 32'(level), 32'h0);
        step(16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R10 bipolar low");
        chk("R10 negative full scale", 32'(level), 32'(17'h18000));

        // constrained random mix
        for (int k = 0; k < 400; k++) begin
            logic [15:0] d;
            logic c, l, u, tw, bp;
            d  = 16'($urandom);
            c  = ($urandom % 3) == 0;
            l  = ($urandom % 4) == 0;
            u  = ($urandom % 3) == 0;
            tw = ($urandom % 5) == 0;
            bp = $urandom % 2;
            step(d, c, l, u, tw, bp, "R2 random");
        end

        // R1 reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 mid-run reset code", 32'(code), 32'h0);
        chk("R1 mid-run reset chg", 32'(code_chg), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule